// File: doc/BRIEF.md
# Two-Part Sequencer Line Buffer

This block stores command lines for a test sequencer and makes them reachable from a 16-bit register bus. Each line is 64 bits and is split into two 32-bit parts, called C and D. A line pointer register picks the line that the next block transfer touches. A separate limit register is kept for the sequencer that consumes the lines.

The host streams data through one of three block ports. The full-line port moves a whole line as four bus words. The C port and the D port each move only their own 32-bit half as two bus words, and they leave the other half of the line untouched. After a complete transfer of a port's own width, the pointer steps to the next line, so a run of back-to-back accesses walks through consecutive lines. A 32-bit part goes to storage in one piece when its low word arrives. The high word waits in a single staging register that all three ports share.

A bus access is a one-cycle strobe with a write flag and a 3-bit register select. Read data is valid combinationally during the strobe cycle. The strobe's clock edge then advances the word sequence.

Top module: `seq_line_buffer`

## Requirements
- R1: After reset the line pointer reads 0, the limit reads 0, and no line transfer is in progress.
- R2: Select 0 is the line pointer. A write keeps the low log2(DEPTH) bits and a read returns them zero-extended. Writing it restarts the next port access at the first word of a line.
- R3: Select 1 is the limit register, LIM_W bits wide. It reads back the written value with the upper bits zero, and only a write to select 1 changes it.
- R4: Select 2 is the full-line port. It moves four words per line in the order C high, C low, D high, D low, and it uses the same order for writes and reads.
- R5: Select 3 is the C port. It moves C high then C low, and a write leaves the D half of that line unchanged.
- R6: Select 4 is the D port. It moves D high then D low, and a write leaves the C half of that line unchanged.
- R7: The line pointer increases by one only after the last word of a line on the port in use, and never in the middle of a line. It wraps from DEPTH-1 to 0.
- R8: A 32-bit part is stored only when its low word is written. A lone high word that is followed by a pointer write leaves storage unchanged.
- R9: An access to a different port in the middle of a line drops the partial line. The new port starts at its own first word, and the pointer does not move.
- R10: Selects 5 to 7 read as zero. A write to them changes no register, no stored data and no word sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Access strobe, one cycle per bus word |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_sel | input | 3 | Register select: 0 pointer, 1 limit, 2 full line, 3 C part, 4 D part |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, valid during the strobe cycle |

## Verification
The bench builds the block with DEPTH = 16 and LIM_W = 10. With 16 lines, one pass of full-line writes runs the pointer through its wrap back to 0. A 4-bit pointer next to a 10-bit limit also shows that each register masks its own upper bits on its own. On that small buffer the bench covers every port order, partial-half preservation, port switching in the middle of a line, and the dropping of a lone staged high word.

// File: rtl/lbuf_pkg.sv
package lbuf_pkg;

   typedef enum logic [1:0] {
      PORT_FULL = 2'd0,
      PORT_C    = 2'd1,
      PORT_D    = 2'd2
   } port_e;

   localparam logic [2:0] SEL_PTR   = 3'd0;
   localparam logic [2:0] SEL_LIM   = 3'd1;
   localparam logic [2:0] SEL_FULL  = 3'd2;
   localparam logic [2:0] SEL_CPART = 3'd3;
   localparam logic [2:0] SEL_DPART = 3'd4;

   // phase encoding: bit 1 = part (0 C, 1 D), bit 0 = half (0 high, 1 low)
   function automatic logic [1:0] first_phase(port_e p);
      return (p == PORT_D) ? 2'd2 : 2'd0;
   endfunction

   function automatic logic [1:0] last_phase(port_e p);
      return (p == PORT_C) ? 2'd1 : 2'd3;
   endfunction

endpackage

// File: rtl/lbuf_part_mem.sv
module lbuf_part_mem #(
   parameter int DEPTH  = 1024,
   parameter int PART_W = 32,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     addr,
   input  logic [PART_W-1:0] wdata,
   output logic [PART_W-1:0] rdata
);

   logic [PART_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end

   assign rdata = mem[addr];

endmodule

// File: rtl/lbuf_word_seq.sv
module lbuf_word_seq
   import lbuf_pkg::*;
#(
   parameter int DEPTH = 1024,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          acc,
   input  port_e         port,
   input  logic          ptr_wr,
   input  logic [AW-1:0] ptr_wdata,
   output logic [AW-1:0] ptr,
   output logic [1:0]    eff_phase,
   output logic          line_done
);

   logic       mid;
   port_e      cur_port;
   logic [1:0] phase;

   always_comb begin
      eff_phase = (mid && cur_port == port) ? phase : first_phase(port);
      line_done = acc && (eff_phase == last_phase(port));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr      <= '0;
         mid      <= 1'b0;
         cur_port <= PORT_FULL;
         phase    <= 2'd0;
      end else if (ptr_wr) begin
         ptr <= ptr_wdata;
         mid <= 1'b0;
      end else if (acc) begin
         if (line_done) begin
            ptr <= ptr + 1'b1;
            mid <= 1'b0;
         end else begin
            mid      <= 1'b1;
            cur_port <= port;
            phase    <= eff_phase + 2'd1;
         end
      end
   end

   p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      line_done && !ptr_wr |=> ptr == AW'($past(ptr) + 1'b1));

   p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !line_done && !ptr_wr |=> $stable(ptr));

   p_ptr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_wr |=> (ptr == $past(ptr_wdata)) && !mid);

   // a partial port left mid-line always waits on its low word
   p_mid_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mid && cur_port != PORT_FULL |-> phase[0]);

endmodule

// File: rtl/seq_line_buffer.sv
module seq_line_buffer
   import lbuf_pkg::*;
#(
   parameter int DEPTH = 1024,
   parameter int BUS_W = 16,
   parameter int LIM_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_req,
   input  logic             bus_we,
   input  logic [2:0]       bus_sel,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [BUS_W-1:0] bus_rdata
);

   localparam int AW     = $clog2(DEPTH);
   localparam int PART_W = 2 * BUS_W;
   localparam int NPART  = 2;

   generate
      if ((1 << AW) != DEPTH) begin : g_chk_depth
         $error("DEPTH must be a power of two");
      end
      if (AW > BUS_W || LIM_W > BUS_W || AW < 1) begin : g_chk_width
         $error("pointer and limit must fit the bus word");
      end
   endgenerate

   logic             is_port;
   port_e            port;
   logic             acc;
   logic [AW-1:0]    ptr;
   logic [1:0]       eff_phase;
   logic             line_done;
   logic             ptr_wr;
   logic [LIM_W-1:0] lim;
   logic [BUS_W-1:0] stage;
   logic [NPART-1:0] part_we;
   logic [PART_W-1:0] part_rd [NPART];

   always_comb begin
      is_port = 1'b1;
      case (bus_sel)
         SEL_FULL:  port = PORT_FULL;
         SEL_CPART: port = PORT_C;
         SEL_DPART: port = PORT_D;
         default: begin
            port    = PORT_FULL;
            is_port = 1'b0;
         end
      endcase
   end

   assign acc    = bus_req && is_port;
   assign ptr_wr = bus_req && bus_we && (bus_sel == SEL_PTR);

   lbuf_word_seq #(.DEPTH(DEPTH)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc       (acc),
      .port      (port),
      .ptr_wr    (ptr_wr),
      .ptr_wdata (bus_wdata[AW-1:0]),
      .ptr       (ptr),
      .eff_phase (eff_phase),
      .line_done (line_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lim   <= '0;
         stage <= '0;
      end else begin
         if (bus_req && bus_we && bus_sel == SEL_LIM) lim <= bus_wdata[LIM_W-1:0];
         if (acc && bus_we && !eff_phase[0]) stage <= bus_wdata;
      end
   end

   generate
      for (genvar i = 0; i < NPART; i++) begin : g_part
         assign part_we[i] = acc && bus_we && eff_phase[0] && (eff_phase[1] == i[0]);
         lbuf_part_mem #(.DEPTH(DEPTH), .PART_W(PART_W)) u_mem (
            .clk   (clk),
            .we    (part_we[i]),
            .addr  (ptr),
            .wdata ({stage, bus_wdata}),
            .rdata (part_rd[i])
         );
      end
   endgenerate

   always_comb begin
      case (bus_sel)
         SEL_PTR: bus_rdata = BUS_W'(ptr);
         SEL_LIM: bus_rdata = BUS_W'(lim);
         SEL_FULL, SEL_CPART, SEL_DPART:
            bus_rdata = eff_phase[0] ? part_rd[eff_phase[1]][BUS_W-1:0]
                                     : part_rd[eff_phase[1]][PART_W-1:BUS_W];
         default: bus_rdata = '0;
      endcase
   end

   // one half of a line per stored write: the other half is never touched
   p_one_part_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(part_we));

   p_lim_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_req && bus_we && bus_sel == SEL_LIM) |=> $stable(lim));

   // storage only changes on a low word of a port access
   p_store_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (part_we != '0) |-> acc && bus_we && eff_phase[0]);

   p_unused_r10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_sel > SEL_DPART |-> (part_we == '0) && !line_done);

endmodule

// File: tb/tb_seq_line_buffer.sv
module tb_seq_line_buffer;

   localparam int DEPTH = 16;
   localparam int LIM_W = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0;
   logic        bus_we = 1'b0;
   logic [2:0]  bus_sel = 3'd0;
   logic [15:0] bus_wdata = 16'h0;
   logic [15:0] bus_rdata;

   int checks = 0;
   int errors = 0;

   logic [31:0] mc [DEPTH];
   logic [31:0] md [DEPTH];

   always #2.5 clk = ~clk;

   seq_line_buffer #(.DEPTH(DEPTH), .BUS_W(16), .LIM_W(LIM_W)) dut (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus(input logic [2:0] s, input logic w, input logic [15:0] d,
                      output logic [15:0] r);
      @(negedge clk);
      bus_req = 1'b1; bus_we = w; bus_sel = s; bus_wdata = d;
      #1 r = bus_rdata;
      @(posedge clk);
      #1 bus_req = 1'b0; bus_we = 1'b0;
   endtask

   task automatic wr(input logic [2:0] s, input logic [15:0] d);
      logic [15:0] r;
      bus(s, 1'b1, d, r);
   endtask

   task automatic rd_chk(input logic [2:0] s, input logic [15:0] exp, input string req);
      logic [15:0] r;
      bus(s, 1'b0, 16'h0, r);
      check(req, r, exp);
   endtask

   task automatic t_reset;
      rd_chk(3'd0, 16'h0000, "R1 pointer after reset");
      rd_chk(3'd1, 16'h0000, "R1 limit after reset");
   endtask

   task automatic t_regs;
      wr(3'd1, 16'h0123);
      wr(3'd0, 16'h0345);
      rd_chk(3'd1, 16'h0123, "R3 limit readback");
      rd_chk(3'd0, 16'h0005, "R2 pointer readback masked");
      wr(3'd1, 16'hFFFF);
      rd_chk(3'd1, 16'h03FF, "R3 limit upper bits zero");
      rd_chk(3'd0, 16'h0005, "R3 limit write leaves pointer");
   endtask

   task automatic t_full;
      wr(3'd0, 16'h0000);
      for (int l = 0; l < DEPTH; l++) begin
         mc[l] = {16'hC100 + 16'(l), 16'hC200 + 16'(l)};
         md[l] = {16'hD100 + 16'(l), 16'hD200 + 16'(l)};
         wr(3'd2, mc[l][31:16]); wr(3'd2, mc[l][15:0]);
         wr(3'd2, md[l][31:16]); wr(3'd2, md[l][15:0]);
         if (l == 3) rd_chk(3'd0, 16'h0004, "R7 pointer after four lines");
      end
      rd_chk(3'd0, 16'h0000, "R7 pointer wraps after top line");
      for (int l = 0; l < DEPTH; l++) begin
         rd_chk(3'd2, mc[l][31:16], "R4 full read C high");
         rd_chk(3'd2, mc[l][15:0],  "R4 full read C low");
         rd_chk(3'd2, md[l][31:16], "R4 full read D high");
         rd_chk(3'd2, md[l][15:0],  "R4 full read D low");
      end
      rd_chk(3'd0, 16'h0000, "R7 pointer wraps after reads");
   endtask

   task automatic t_cpart;
      wr(3'd0, 16'h0001);
      for (int l = 1; l <= 2; l++) begin
         mc[l] = {16'h5A00 + 16'(l), 16'hA500 + 16'(l)};
         wr(3'd3, mc[l][31:16]);
         if (l == 1) rd_chk(3'd0, 16'h0001, "R7 no step mid-line");
         wr(3'd3, mc[l][15:0]);
      end
      rd_chk(3'd0, 16'h0003, "R7 C port steps per line");
      wr(3'd0, 16'h0000);
      for (int l = 0; l < 4; l++) begin
         rd_chk(3'd2, mc[l][31:16], "R5 C high after C writes");
         rd_chk(3'd2, mc[l][15:0],  "R5 C low after C writes");
         rd_chk(3'd2, md[l][31:16], "R5 D high kept");
         rd_chk(3'd2, md[l][15:0],  "R5 D low kept");
      end
   endtask

   task automatic t_dpart;
      wr(3'd0, 16'h0002);
      for (int l = 2; l <= 3; l++) begin
         md[l] = {16'h3C00 + 16'(l), 16'hC300 + 16'(l)};
         wr(3'd4, md[l][31:16]); wr(3'd4, md[l][15:0]);
      end
      rd_chk(3'd0, 16'h0004, "R7 D port steps per line");
      wr(3'd0, 16'h0000);
      for (int l = 0; l < 4; l++) begin
         rd_chk(3'd4, md[l][31:16], "R6 D port read high");
         rd_chk(3'd4, md[l][15:0],  "R6 D port read low");
      end
      rd_chk(3'd0, 16'h0004, "R7 D port read steps");
      wr(3'd0, 16'h0000);
      for (int l = 0; l < 4; l++) begin
         rd_chk(3'd3, mc[l][31:16], "R6 C high kept");
         rd_chk(3'd3, mc[l][15:0],  "R6 C low kept");
      end
   endtask

   task automatic t_wrap_part;
      wr(3'd0, 16'h000F);
      mc[15] = 32'h0F0F_F0F0;
      wr(3'd3, 16'h0F0F); wr(3'd3, 16'hF0F0);
      rd_chk(3'd0, 16'h0000, "R7 C port wraps");
      wr(3'd0, 16'h000F);
      rd_chk(3'd2, mc[15][31:16], "R5 top line C high");
      rd_chk(3'd2, mc[15][15:0],  "R5 top line C low");
      rd_chk(3'd2, md[15][31:16], "R5 top line D high kept");
      rd_chk(3'd2, md[15][15:0],  "R5 top line D low kept");
   endtask

   task automatic t_stage;
      wr(3'd0, 16'h0005);
      wr(3'd3, 16'hAAAA);
      rd_chk(3'd0, 16'h0005, "R8 pointer holds after high word");
      wr(3'd0, 16'h0005);
      rd_chk(3'd3, mc[5][31:16], "R8 lone high word not stored");
      rd_chk(3'd3, mc[5][15:0],  "R2 pointer write restarts line");
      rd_chk(3'd0, 16'h0006, "R2 restarted line completes");
   endtask

   task automatic t_switch;
      wr(3'd0, 16'h0006);
      wr(3'd3, 16'h1111);
      wr(3'd4, 16'h2222);
      rd_chk(3'd0, 16'h0006, "R9 pointer kept on switch");
      wr(3'd4, 16'h3333);
      md[6] = 32'h2222_3333;
      rd_chk(3'd0, 16'h0007, "R9 new port completes line");
      wr(3'd0, 16'h0006);
      rd_chk(3'd2, mc[6][31:16], "R9 dropped C high");
      rd_chk(3'd2, mc[6][15:0],  "R9 C low kept");
      rd_chk(3'd2, md[6][31:16], "R9 D high from new port");
      rd_chk(3'd2, md[6][15:0],  "R9 D low from new port");
      rd_chk(3'd2, mc[7][31:16], "R9 read line begins");
      rd_chk(3'd4, md[7][31:16], "R9 read switch starts at D high");
      rd_chk(3'd4, md[7][15:0],  "R9 read switch D low");
      rd_chk(3'd0, 16'h0008, "R9 read switch pointer");
   endtask

   task automatic t_unused;
      wr(3'd0, 16'h0009);
      wr(3'd3, 16'h7777);
      wr(3'd6, 16'hFFFF);
      wr(3'd5, 16'h1234);
      wr(3'd3, 16'h8888);
      mc[9] = 32'h7777_8888;
      rd_chk(3'd5, 16'h0000, "R10 select 5 reads zero");
      rd_chk(3'd6, 16'h0000, "R10 select 6 reads zero");
      rd_chk(3'd7, 16'h0000, "R10 select 7 reads zero");
      rd_chk(3'd0, 16'h000A, "R10 pointer unchanged by unused writes");
      rd_chk(3'd1, 16'h03FF, "R10 limit unchanged");
      wr(3'd0, 16'h0009);
      rd_chk(3'd2, mc[9][31:16], "R10 staged high kept");
      rd_chk(3'd2, mc[9][15:0],  "R10 line completed");
      rd_chk(3'd2, md[9][31:16], "R10 D high kept");
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset;
      t_regs;
      t_full;
      t_cpart;
      t_dpart;
      t_wrap_part;
      t_stage;
      t_switch;
      t_unused;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule